// File: doc/BRIEF.md
# SPI Parameter Query Responder

This block is an SPI slave that answers parameter queries in two separate chip-select frames. In the first frame the host sends the request command byte `0x20` and then one selector byte. When the selector byte is complete, the block reads the chosen 64-bit word from a parameter bank outside the block. It keeps a private copy of that word. In a later frame the host sends the readout command byte `0x26` and then clocks eight filler bytes. During those eight bytes the block returns the stored word on MISO.

The SPI pins are oversampled in the system clock domain through two-stage synchronisers. The bus runs in mode 0: SCLK idles low, MOSI is sampled on SCLK rising edges and MISO changes on SCLK falling edges. Every byte travels MSB first. A frame starts when CS goes low. If CS goes high before the frame is complete, the frame is abandoned. When MISO carries no result data, it is driven low.

Top module: `spi_param_query`

## Requirements
- R1: After reset, MISO is low. A readout performed before any completed request returns 64 zero bits.
- R2: A frame whose first byte is `0x20` and whose second byte is a selector S in the range 0 to NUM_PARAMS-1 stores the word that the bank presents for S. The bank is read once, when the selector byte completes.
- R3: In a frame whose first byte is `0x26`, bytes 1 to 8 carry the stored word on MISO. Byte 1 carries bits 63..56 and byte 8 carries bits 7..0, each byte MSB first.
- R4: MISO stays low for the whole of the command byte of every frame and for the selector byte of a request frame.
- R5: A selector equal to or greater than NUM_PARAMS stores all zeros, whatever the bank presents.
- R6: A readout returns the word captured at request time, even if the bank contents change after the request.
- R7: If CS rises before the selector byte of a request frame has fully arrived, the stored word is left unchanged.
- R8: A frame with any other first byte leaves the stored word unchanged and keeps MISO low for the whole frame.
- R9: MISO changes only after an SCLK falling edge, or when CS is released.
- R10: In a readout frame, MISO is low for any SCLK cycles after the 64th result bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCLK by at least 8x |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock from the host (idles low) |
| spi_mosi | input | 1 | Serial data from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_miso | output | 1 | Serial data to the host |
| bank_sel | output | 8 | Selector presented to the parameter bank |
| bank_data | input | 64 | Word the bank returns for `bank_sel` |

## Verification
The stored word is not visible at the ports. A wrong capture, a missed capture or a stray capture of the snapshot therefore shows up only at the next readout frame, as a mismatch in one of the eight payload bytes. The bench issues a readout after every frame that could have disturbed the word, so a corruption is reported at most one frame after it happens. Faults in the bit or byte counters show up straight away as shifted or misplaced MISO bits, or as non-zero bits in the command byte of the same frame.

// File: rtl/spi_query_pkg.sv
// Shared constants for the SPI parameter query responder.
// Assumes 8-bit command bytes; the command values are fixed by the host protocol.
package spi_query_pkg;
    localparam int          BYTE_W  = 8;
    localparam logic [7:0]  REQ_CMD = 8'h20;   // request: next byte selects a parameter
    localparam logic [7:0]  RD_CMD  = 8'h26;   // readout: next bytes clock out the snapshot
endpackage

// File: rtl/spi_pin_sync.sv
// Multi-stage synchroniser for the asynchronous SPI pins, with the previous
// synchronised value kept for edge detection.
// Assumes the pins change slowly relative to clk (several clk per SCLK phase).
module spi_pin_sync #(
    parameter int               W       = 3,
    parameter int               STAGES  = 2,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic [W-1:0] dprev
);
    logic [W-1:0] stage_q [STAGES];

    // Shift the pins through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    // Keep the last synchronised value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) dprev <= RST_VAL;
        else        dprev <= stage_q[STAGES-1];
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/spi_byte_rx.sv
// Assembles MOSI bits into bytes (MSB first) on SCLK rising strobes and numbers
// the bytes within a frame. Everything is cleared while chip select is inactive.
// Assumes sclk_rise and mosi come from the same synchroniser delay.
module spi_byte_rx #(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sclk_rise,
    input  logic              mosi,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_data,
    output logic [CNT_W-1:0]  byte_num
);
    localparam int BIT_W = $clog2(BYTE_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    logic [BIT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;

    // Shift in MOSI, count bits, and issue one strobe for each complete byte.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            cnt       <= '0;
            byte_done <= 1'b0;
            byte_data <= '0;
            byte_num  <= '0;
        end else begin
            byte_done <= 1'b0;
            if (sclk_rise) begin
                shreg   <= {shreg[BYTE_W-2:0], mosi};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == LAST_BIT) begin
                    byte_done <= 1'b1;
                    byte_data <= {shreg[BYTE_W-2:0], mosi};
                    byte_num  <= cnt;
                    if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R3 support: a byte strobe never occurs in two consecutive cycles.
    a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done);
endmodule

// File: rtl/spi_query_ctrl.sv
// Decodes the command byte of each frame. A request frame selects a bank entry
// and then captures it into the snapshot register. A readout frame arms the
// MISO transmitter.
// Assumes the bank responds combinationally to bank_sel within one clk.
module spi_query_ctrl #(
    parameter int PARAM_W    = 64,
    parameter int SEL_W      = 8,
    parameter int NUM_PARAMS = 8,
    parameter int CNT_W      = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_act,
    input  logic               byte_done,
    input  logic [SEL_W-1:0]   byte_data,
    input  logic [CNT_W-1:0]   byte_num,
    input  logic [PARAM_W-1:0] bank_data,
    output logic [SEL_W-1:0]   bank_sel,
    output logic               rd_arm,
    output logic [PARAM_W-1:0] snap
);
    import spi_query_pkg::*;

    logic [SEL_W-1:0] cmd_q;
    logic [SEL_W-1:0] sel_q;
    logic             load_pend;
    logic             sel_known;

    assign sel_known = (32'(sel_q) < NUM_PARAMS);
    assign bank_sel  = sel_q;

    // Record the command byte and react to the second byte of a request frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= '0;
            sel_q     <= '0;
            load_pend <= 1'b0;
            rd_arm    <= 1'b0;
        end else begin
            load_pend <= 1'b0;
            rd_arm    <= 1'b0;
            if (!cs_act) begin
                cmd_q <= '0;
            end else if (byte_done) begin
                if (byte_num == '0) begin
                    cmd_q  <= byte_data;
                    rd_arm <= (byte_data == SEL_W'(RD_CMD));
                end else if (byte_num == CNT_W'(1) && cmd_q == SEL_W'(REQ_CMD)) begin
                    sel_q     <= byte_data;
                    load_pend <= 1'b1;
                end
            end
        end
    end

    // Capture the selected bank word (or zeros for an unknown selector).
    always_ff @(posedge clk) begin
        if (!rst_n)         snap <= '0;
        else if (load_pend) snap <= sel_known ? bank_data : '0;
    end

    // R7/R8: the snapshot changes only as the result of a completed request.
    a_r7_snap_only_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(snap) |-> $past(load_pend));
    // R5: an unknown selector leaves zeros in the snapshot.
    a_r5_unknown_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (load_pend && !sel_known) |=> (snap == '0));
    // R2: a known selector captures the word the bank presented.
    a_r2_capture_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (load_pend && sel_known) |=> (snap == $past(bank_data)));
endmodule

// File: rtl/spi_miso_tx.sv
// Shifts the snapshot out on MISO, MSB first, one bit per SCLK falling edge,
// once a readout frame is armed. MISO is low in every other case.
// Assumes the snapshot is stable for the length of a readout frame.
module spi_miso_tx #(
    parameter int PARAM_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_act,
    input  logic               sclk_fall,
    input  logic               arm,
    input  logic [PARAM_W-1:0] snap,
    output logic               miso
);
    localparam int IDX_W = $clog2(PARAM_W + 1);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(PARAM_W);

    logic             active;
    logic [IDX_W-1:0] idx;

    // Track the readout state and drive one bit on every falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            active <= 1'b0;
            idx    <= '0;
            miso   <= 1'b0;
        end else if (arm) begin
            active <= 1'b1;
            idx    <= '0;
        end else if (active && sclk_fall) begin
            if (idx != IDX_END) begin
                miso <= snap[PARAM_W - 1 - int'(idx)];
                idx  <= idx + 1'b1;
            end else begin
                miso <= 1'b0;
            end
        end
    end

    // R4/R8: outside a readout, MISO stays low.
    a_r4_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !miso);
    // R9: MISO moves only after a falling strobe or a chip-select release.
    a_r9_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(miso) |-> $past(sclk_fall || !cs_act));
    // R10: the bit index never runs past the word length.
    a_r10_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= IDX_END);
endmodule

// File: rtl/spi_param_query.sv
// Top level of the SPI parameter query responder. It synchronises the SPI pins,
// assembles bytes, decodes request and readout frames, and serialises the snapshot.
// Assumes clk runs at least 8x faster than SCLK and that SPI is mode 0.
module spi_param_query #(
    parameter int PARAM_W    = 64,
    parameter int SEL_W      = 8,
    parameter int NUM_PARAMS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spi_sclk,
    input  logic               spi_mosi,
    input  logic               spi_cs_n,
    output logic               spi_miso,
    output logic [SEL_W-1:0]   bank_sel,
    input  logic [PARAM_W-1:0] bank_data
);
    localparam int CNT_W = 4;

    logic [2:0]         pins_s, pins_p;
    logic               sclk_rise, sclk_fall, cs_act;
    logic               byte_done, rd_arm;
    logic [SEL_W-1:0]   byte_data;
    logic [CNT_W-1:0]   byte_num;
    logic [PARAM_W-1:0] snap;

    spi_pin_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .din({spi_cs_n, spi_sclk, spi_mosi}),
        .dout(pins_s), .dprev(pins_p)
    );

    assign cs_act    = !pins_s[2];
    assign sclk_rise =  pins_s[1] && !pins_p[1];
    assign sclk_fall = !pins_s[1] &&  pins_p[1];

    spi_byte_rx #(.BYTE_W(SEL_W), .CNT_W(CNT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_rise(sclk_rise),
        .mosi(pins_s[0]), .byte_done(byte_done), .byte_data(byte_data),
        .byte_num(byte_num)
    );

    spi_query_ctrl #(.PARAM_W(PARAM_W), .SEL_W(SEL_W), .NUM_PARAMS(NUM_PARAMS),
                     .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .byte_done(byte_done),
        .byte_data(byte_data), .byte_num(byte_num), .bank_data(bank_data),
        .bank_sel(bank_sel), .rd_arm(rd_arm), .snap(snap)
    );

    spi_miso_tx #(.PARAM_W(PARAM_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_fall(sclk_fall),
        .arm(rd_arm), .snap(snap), .miso(spi_miso)
    );

    // R1: MISO is low in the cycle after reset.
    a_r1_reset_low: assert property (@(posedge clk)
        !rst_n |=> !spi_miso);
endmodule

// File: tb/tb_spi_param_query.sv
// Self-checking bench: a behavioural model of the stored word predicts every
// MISO byte; each byte the host receives is compared with the prediction.
module tb_spi_param_query;
    localparam int HALF = 8;  // clk cycles per SCLK phase

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1;
    logic        miso;
    logic [7:0]  bank_sel;
    logic [63:0] bank_data;
    logic [63:0] bank [8];
    logic [63:0] model_word;
    logic [7:0]  tx_bytes [12];
    int          n_tests = 0, n_fail = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;  // 200 MHz

    always_comb bank_data = (bank_sel < 8) ? bank[bank_sel[2:0]] : 64'hF0F0_1234_CAFE_BEEF;

    spi_param_query dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_mosi(mosi),
        .spi_cs_n(cs_n), .spi_miso(miso), .bank_sel(bank_sel), .bank_data(bank_data)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Run one frame of nbytes; cut_bits >= 0 releases CS after that many bits.
    task automatic frame(input int nbytes, input int cut_bits, input string req);
        bit          is_rd = (tx_bytes[0] == 8'h26);
        int          sent = 0;
        bit          cut = 0;
        logic [7:0]  got;
        logic [7:0]  exp;
        cs_n = 1'b0;
        wait_clk(6);
        for (int k = 0; k < nbytes && !cut; k++) begin
            got = '0;
            for (int j = 7; j >= 0; j--) begin
                if (cut_bits >= 0 && sent == cut_bits) begin
                    cut = 1;
                    break;
                end
                mosi = tx_bytes[k][j];
                wait_clk(HALF);
                got[j] = miso;   // sampled just before the rising edge
                sclk = 1'b1;
                wait_clk(HALF);
                sclk = 1'b0;
                sent++;
            end
            if (!cut) begin
                exp = (is_rd && k >= 1 && k <= 8) ? model_word[8*(9-k)-1 -: 8] : 8'h00;
                check(k == 0 ? "R4" : req, {56'd0, got}, {56'd0, exp});
            end
        end
        wait_clk(HALF);
        cs_n = 1'b1;
        mosi = 1'b0;
        wait_clk(10);
        if (tx_bytes[0] == 8'h20 && (cut_bits < 0 || cut_bits >= 16) && nbytes >= 2)
            model_word = (tx_bytes[1] < 8) ? bank[tx_bytes[1][2:0]] : 64'd0;
    endtask

    task automatic request(input logic [7:0] sel, input string req);
        tx_bytes[0] = 8'h20; tx_bytes[1] = sel;
        frame(2, -1, req);
    endtask

    task automatic readout(input int nbytes, input string req);
        tx_bytes[0] = 8'h26;
        for (int i = 1; i < 12; i++) tx_bytes[i] = 8'h00;
        frame(nbytes, -1, req);
    endtask

    initial begin
        for (int i = 0; i < 8; i++)
            bank[i] = {8'(i), 8'hA5, 8'h3C, 8'(8'h10 * i), 32'h0123_4567 ^ (32'(i) * 32'h1111)};
        model_word = '0;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
        check("R1", {63'd0, miso}, 64'd0);           // R1 reset state
        readout(9, "R1");                             // R1 zero word before any request
        request(8'h03, "R4");                         // R2/R4 request, MISO low
        readout(9, "R3");                             // R2 R3 byte order
        request(8'h07, "R4");
        readout(9, "R2");                             // R2 last valid selector
        request(8'h00, "R4");
        readout(9, "R3");
        request(8'h08, "R4");                         // R5 first unknown selector
        readout(9, "R5");
        request(8'hFF, "R4");
        readout(9, "R5");
        request(8'h05, "R4");
        bank[5] = 64'hDEAD_0000_BEEF_1111;            // R6 bank change after request
        readout(9, "R6");
        tx_bytes[0] = 8'h20; tx_bytes[1] = 8'h02;     // R7 abort inside selector byte
        frame(2, 12, "R7");
        readout(9, "R7");
        tx_bytes[0] = 8'h20;                          // R7 abort right after command
        frame(2, 8, "R7");
        readout(9, "R7");
        tx_bytes[0] = 8'h21; tx_bytes[1] = 8'h01; tx_bytes[2] = 8'h26;  // R8 other command
        frame(3, -1, "R8");
        readout(9, "R8");
        request(8'h06, "R4");
        readout(11, "R10");                           // R10 extra clocks give zeros, R9 timing
        readout(5, "R9");                             // partial readout then fresh frame
        readout(9, "R9");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule